// File: doc/BRIEF.md
# CRC32C Move and Check Engine

This block folds a byte stream into a running CRC32C accumulator. Depending on the operation code, it can also copy every byte to an output stream. Each piece of work is described by one descriptor on ports, carrying these fields:

- an opcode;
- a byte count;
- a 32-bit seed and a flag that loads the seed;
- a location flag;
- a reference CRC.

The source bytes arrive on a valid/ready input stream. Copied bytes leave on a valid/ready output stream.

The accumulator survives from one descriptor to the next. A long buffer can therefore be checked as a chain of shorter pieces. Store forms publish the result in wire format, which is the bitwise inverse of the reflected accumulator. The result is either presented on `crc_o` when the descriptor finishes, or appended to the output stream. Test forms compare the wire value against a reference. The reference is either taken from the descriptor or read as four bytes trailing the data. A mismatch halts the channel until it is explicitly cleared.

Top module: `crc_move_engine`

## Requirements
- R1: The opcode is decoded as follows. Bits [7:6] = 01 selects move-and-compute and 10 selects compute-only. Bits [5:2] must be zero. Bits [1:0] = 01 is plain, 10 is test and 11 is store. So 0x41/0x42/0x43 are the move forms and 0x81/0x82/0x83 the compute-only forms. Any other opcode consumes no bytes, leaves the accumulator unchanged, finishes with `crc_err_o` and halts the channel.
- R2: Every accepted source byte is folded into the accumulator with the reflected CRC32C polynomial 0x82F63B78, least significant bit first, one byte per accepted beat. Exactly `desc_len_i` bytes are folded.
- R3: The accumulator resets to 0xFFFFFFFF and keeps its value between descriptors. It is loaded with `desc_seed_i`, unchanged, only when a descriptor is accepted with `desc_use_seed_i` set. `crc_o` always shows the wire format of the accumulator, which is its bitwise inverse.
- R4: Move forms pass each source byte to the output stream unchanged and in order, with output backpressure stalling the input. Compute-only forms emit nothing during the data phase.
- R5: A store form with the location flag set appends four bytes of the wire CRC after the data on the output stream, least significant byte first. This holds for both move and compute-only store. With the flag clear, nothing is appended.
- R6: A test form with the location flag set reads the four input bytes after the data as the reference, least significant byte first. These bytes are neither folded nor copied. With the flag clear, the reference is `desc_ref_i`.
- R7: A test mismatch, or a bad opcode, pulses `crc_err_o` together with `done_o`, and `halt_o` rises in the next cycle. `halt_o` stays high until `clr_halt_i` is sampled high in a cycle with no new error; an error in the same cycle as a clear wins.
- R8: While `halt_o` is high, `desc_ready_o` is low and offered descriptors are ignored, so the accumulator does not change.
- R9: `done_o` is a one-cycle pulse for each descriptor. It follows the last data byte and any trailing bytes, and while it is high `crc_o` holds the final result.
- R10: After reset, `halt_o`, `done_o` and `out_valid_o` are low, `desc_ready_o` is high and `crc_o` is 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_halt_i | input | 1 | Clears the halt state |
| desc_valid_i | input | 1 | Descriptor offered |
| desc_ready_o | output | 1 | Descriptor can be taken |
| desc_op_i | input | 8 | Operation code |
| desc_len_i | input | LEN_W | Number of source bytes |
| desc_seed_i | input | 32 | Seed value for the accumulator |
| desc_use_seed_i | input | 1 | Load the seed on acceptance |
| desc_loc_i | input | 1 | Location flag: result or reference travels in the stream |
| desc_ref_i | input | 32 | Reference CRC (wire format) for test forms |
| in_valid_i | input | 1 | Source byte valid |
| in_data_i | input | 8 | Source byte |
| in_ready_o | output | 1 | Source byte taken |
| out_valid_o | output | 1 | Output byte valid |
| out_data_o | output | 8 | Output byte |
| out_ready_i | input | 1 | Output byte taken |
| crc_o | output | 32 | Accumulator in wire format |
| done_o | output | 1 | Descriptor finished |
| crc_err_o | output | 1 | Mismatch or bad opcode, with done |
| halt_o | output | 1 | Channel halted |

## Verification
A failing test descriptor can finish in the same cycle as a request to clear the halt. The bench holds `clr_halt_i` high for the whole of some failing test descriptors and for a bad opcode. It then expects `halt_o` to be high in the cycle after `done_o`, and to fall only once a clear is applied in a later cycle with no error. A second pairing is a move beat under output backpressure: input and output bubbles are interleaved with different periods, and the copied stream and the folded CRC must both remain exact.

// File: rtl/crcmc_pkg.sv
package crcmc_pkg;
  localparam logic [31:0] CRC_POLY = 32'h82F63B78;
  localparam logic [31:0] ACC_INIT = 32'hFFFF_FFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_TAIL_OUT,
    ST_TAIL_IN,
    ST_FIN
  } state_t;

  typedef struct packed {
    logic ok;
    logic move;
    logic test;
    logic store;
  } op_info_t;

  function automatic op_info_t decode_op(input logic [7:0] op);
    op_info_t r;
    r.move  = (op[7:6] == 2'b01);
    r.ok    = (op[7:6] == 2'b01 || op[7:6] == 2'b10) && (op[5:2] == 4'd0) &&
              (op[1:0] != 2'b00);
    r.test  = (op[1:0] == 2'b10);
    r.store = (op[1:0] == 2'b11);
    return r;
  endfunction

  function automatic logic [31:0] crc32c_byte(input logic [31:0] acc,
                                              input logic [7:0] b);
    logic [31:0] c;
    c = acc ^ {24'd0, b};
    for (int i = 0; i < 8; i++)
      c = c[0] ? ((c >> 1) ^ CRC_POLY) : (c >> 1);
    return c;
  endfunction

  function automatic logic [31:0] wire_of(input logic [31:0] acc);
    return ~acc;
  endfunction

  function automatic state_t after_data(input op_info_t i, input logic loc);
    if (i.store && loc)     return ST_TAIL_OUT;
    else if (i.test && loc) return ST_TAIL_IN;
    else                    return ST_FIN;
  endfunction
endpackage

// File: rtl/crc_accum.sv
module crc_accum
  import crcmc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] seed_i,
  input  logic        step_i,
  input  logic [7:0]  byte_i,
  output logic [31:0] acc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_o <= ACC_INIT;
    else if (load_i) acc_o <= seed_i;
    else if (step_i) acc_o <= crc32c_byte(acc_o, byte_i);
  end

  AST_ACC_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !step_i) |=> $stable(acc_o)); // R3
endmodule

// File: rtl/crc_ctrl.sv
module crc_ctrl
  import crcmc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_halt_i,
  input  logic             desc_valid_i,
  output logic             desc_ready_o,
  input  logic [7:0]       desc_op_i,
  input  logic [LEN_W-1:0] desc_len_i,
  input  logic             desc_use_seed_i,
  input  logic             desc_loc_i,
  input  logic [31:0]      desc_ref_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  input  logic             out_ready_i,
  input  logic [31:0]      acc_i,
  output logic             load_o,
  output logic             step_o,
  output logic             done_o,
  output logic             err_o,
  output logic             halt_o
);
  state_t           state;
  op_info_t         info_q;
  op_info_t         info_d;
  logic             loc_q;
  logic [31:0]      ref_q;
  logic [LEN_W-1:0] cnt;
  logic [1:0]       tail_cnt;
  logic             accept;
  logic [31:0]      wire_v;
  logic             mismatch;

  assign info_d       = decode_op(desc_op_i);
  assign desc_ready_o = (state == ST_IDLE) && !halt_o;
  assign accept       = desc_valid_i && desc_ready_o;
  assign load_o       = accept && info_d.ok && desc_use_seed_i;
  assign wire_v       = wire_of(acc_i);
  assign mismatch     = info_q.test && (ref_q != wire_v);
  assign done_o       = (state == ST_FIN);
  assign err_o        = done_o && (!info_q.ok || mismatch);
  assign step_o       = (state == ST_DATA) && in_valid_i && in_ready_o;

  always_comb begin
    in_ready_o  = 1'b0;
    out_valid_o = 1'b0;
    out_data_o  = in_data_i;
    case (state)
      ST_DATA: begin
        in_ready_o  = info_q.move ? out_ready_i : 1'b1;
        out_valid_o = info_q.move && in_valid_i;
      end
      ST_TAIL_OUT: begin
        out_valid_o = 1'b1;
        out_data_o  = wire_v[8*tail_cnt +: 8];
      end
      ST_TAIL_IN: in_ready_o = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      info_q   <= '0;
      loc_q    <= 1'b0;
      ref_q    <= '0;
      cnt      <= '0;
      tail_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          info_q   <= info_d;
          loc_q    <= desc_loc_i;
          ref_q    <= desc_ref_i;
          cnt      <= desc_len_i;
          tail_cnt <= '0;
          if (!info_d.ok)               state <= ST_FIN;
          else if (desc_len_i == '0)    state <= after_data(info_d, desc_loc_i);
          else                          state <= ST_DATA;
        end
        ST_DATA: if (step_o) begin
          cnt <= cnt - LEN_W'(1);
          if (cnt == LEN_W'(1)) state <= after_data(info_q, loc_q);
        end
        ST_TAIL_OUT: if (out_ready_i) begin
          tail_cnt <= tail_cnt + 2'd1;
          if (tail_cnt == 2'd3) state <= ST_FIN;
        end
        ST_TAIL_IN: if (in_valid_i) begin
          ref_q    <= {in_data_i, ref_q[31:8]};
          tail_cnt <= tail_cnt + 2'd1;
          if (tail_cnt == 2'd3) state <= ST_FIN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          halt_o <= 1'b0;
    else if (err_o)      halt_o <= 1'b1;
    else if (clr_halt_i) halt_o <= 1'b0;
  end

  AST_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> halt_o); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_o && !clr_halt_i) |=> halt_o); // R7
  AST_HALT_NO_DESC: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> !desc_ready_o); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R9
  AST_REF_NOT_FOLDED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_TAIL_IN) |=> $stable(acc_i)); // R6
  AST_SILENT_COMPUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && !info_q.move) |-> !out_valid_o); // R4
endmodule

// File: rtl/crc_move_engine.sv
module crc_move_engine
  import crcmc_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_halt_i,
  input  logic             desc_valid_i,
  output logic             desc_ready_o,
  input  logic [7:0]       desc_op_i,
  input  logic [LEN_W-1:0] desc_len_i,
  input  logic [31:0]      desc_seed_i,
  input  logic             desc_use_seed_i,
  input  logic             desc_loc_i,
  input  logic [31:0]      desc_ref_i,
  input  logic             in_valid_i,
  input  logic [7:0]       in_data_i,
  output logic             in_ready_o,
  output logic             out_valid_o,
  output logic [7:0]       out_data_o,
  input  logic             out_ready_i,
  output logic [31:0]      crc_o,
  output logic             done_o,
  output logic             crc_err_o,
  output logic             halt_o
);
  logic [31:0] acc;
  logic        load;
  logic        step;

  crc_accum u_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load),
    .seed_i (desc_seed_i),
    .step_i (step),
    .byte_i (in_data_i),
    .acc_o  (acc)
  );

  crc_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .clr_halt_i      (clr_halt_i),
    .desc_valid_i    (desc_valid_i),
    .desc_ready_o    (desc_ready_o),
    .desc_op_i       (desc_op_i),
    .desc_len_i      (desc_len_i),
    .desc_use_seed_i (desc_use_seed_i),
    .desc_loc_i      (desc_loc_i),
    .desc_ref_i      (desc_ref_i),
    .in_valid_i      (in_valid_i),
    .in_data_i       (in_data_i),
    .in_ready_o      (in_ready_o),
    .out_valid_o     (out_valid_o),
    .out_data_o      (out_data_o),
    .out_ready_i     (out_ready_i),
    .acc_i           (acc),
    .load_o          (load),
    .step_o          (step),
    .done_o          (done_o),
    .err_o           (crc_err_o),
    .halt_o          (halt_o)
  );

  assign crc_o = wire_of(acc);

  AST_DONE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> $stable(crc_o)); // R9
endmodule

// File: tb/crc_move_engine_tb.sv
`timescale 1ns/1ps
module crc_move_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_halt_i = 1'b0;
  logic        desc_valid_i = 1'b0;
  logic        desc_ready_o;
  logic [7:0]  desc_op_i = 8'h00;
  logic [7:0]  desc_len_i = 8'd0;
  logic [31:0] desc_seed_i = 32'd0;
  logic        desc_use_seed_i = 1'b0;
  logic        desc_loc_i = 1'b0;
  logic [31:0] desc_ref_i = 32'd0;
  logic        in_valid_i = 1'b0;
  logic [7:0]  in_data_i = 8'd0;
  logic        in_ready_o;
  logic        out_valid_o;
  logic [7:0]  out_data_o;
  logic        out_ready_i = 1'b0;
  logic [31:0] crc_o;
  logic        done_o;
  logic        crc_err_o;
  logic        halt_o;

  always #2 clk = ~clk;

  crc_move_engine #(.LEN_W(8)) dut_i (.*);

  int          n_chk = 0;
  int          n_err = 0;
  logic [31:0] model = 32'hFFFF_FFFF;
  logic [31:0] lfsr = 32'h1D2C_3B4A;
  logic [7:0]  src [0:31];

  function automatic logic [31:0] fold(input logic [31:0] a, input logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      logic fb;
      fb = a[0] ^ b[k];
      a  = a >> 1;
      if (fb) a = a ^ 32'h82F63B78;
    end
    return a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic next_rand(output logic [7:0] b);
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    b = lfsr[7:0] ^ lfsr[23:16];
  endtask

  task automatic run(input logic [7:0] op, input int len, input logic [31:0] seed,
                     input bit use_seed, input bit loc, input bit corrupt, input bit hold_clr);
    bit          ok, mv, tst, sto, exp_err, seen;
    logic [31:0] wv, rv, crc_got, halt_crc;
    logic [7:0]  stm [0:40];
    logic [7:0]  xo  [0:40];
    int          n_in, n_xo, ii, no, bad;
    bit          err_got;
    ok  = (op == 8'h41 || op == 8'h42 || op == 8'h43 ||
           op == 8'h81 || op == 8'h82 || op == 8'h83);
    mv  = (op[7:6] == 2'b01);
    tst = (op[1:0] == 2'b10);
    sto = (op[1:0] == 2'b11);
    if (ok) begin
      if (use_seed) model = seed;
      for (int i = 0; i < len; i++) model = fold(model, src[i]);
    end
    wv = ~model;
    rv = corrupt ? (wv ^ 32'h0001_0000) : wv;
    n_in = 0; n_xo = 0;
    if (ok) begin
      for (int i = 0; i < len; i++) begin
        stm[n_in] = src[i]; n_in++;
        if (mv) begin xo[n_xo] = src[i]; n_xo++; end
      end
      if (tst && loc) for (int i = 0; i < 4; i++) begin stm[n_in] = rv[8*i +: 8]; n_in++; end
      if (sto && loc) for (int i = 0; i < 4; i++) begin xo[n_xo] = wv[8*i +: 8]; n_xo++; end
    end
    exp_err = !ok || (tst && corrupt);

    @(negedge clk);
    desc_op_i = op; desc_len_i = 8'(len); desc_seed_i = seed;
    desc_use_seed_i = use_seed; desc_loc_i = loc; desc_ref_i = rv;
    desc_valid_i = 1'b1; clr_halt_i = hold_clr;
    #1 chk("R8 ready when not halted", {31'd0, desc_ready_o}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    desc_valid_i = 1'b0;
    ii = 0; no = 0; bad = 0; seen = 0; crc_got = 0; err_got = 0;
    for (int c = 0; c < 300; c++) begin
      in_valid_i  = (ii < n_in) && ((c % 3) != 2);
      in_data_i   = (ii < n_in) ? stm[ii] : 8'h00;
      out_ready_i = ((c % 4) != 3);
      #1;
      if (out_valid_o && out_ready_i) begin
        if (no >= n_xo || out_data_o !== xo[no]) bad++;
        no++;
      end
      if (in_valid_i && in_ready_o) ii++;
      if (done_o) begin seen = 1; crc_got = crc_o; err_got = crc_err_o; end
      @(posedge clk);
      @(negedge clk);
      if (seen) break;
    end
    in_valid_i = 1'b0;
    chk("R9 done seen", {31'd0, seen}, 32'd1);
    chk("R2 R3 crc result", crc_got, wv);
    chk("R4 R5 output byte errors", bad, 0);
    chk("R4 R5 output byte count", no, n_xo);
    chk("R6 input bytes consumed", ii, n_in);
    chk("R1 R7 error flag", {31'd0, err_got}, {31'd0, exp_err});
    #1;
    chk("R9 done is one cycle", {31'd0, done_o}, 32'd0);
    chk("R7 halt after done", {31'd0, halt_o}, {31'd0, exp_err});
    if (exp_err) begin
      halt_crc = crc_o;
      clr_halt_i = 1'b0;
      desc_op_i = 8'h81; desc_use_seed_i = 1'b1; desc_seed_i = 32'h1234_5678;
      desc_len_i = 8'd0; desc_valid_i = 1'b1;
      for (int c = 0; c < 3; c++) begin
        @(negedge clk); #1;
        chk("R8 ready low while halted", {31'd0, desc_ready_o}, 32'd0);
        chk("R7 halt sticky", {31'd0, halt_o}, 32'd1);
      end
      desc_valid_i = 1'b0;
      chk("R8 ignored descriptor", crc_o, halt_crc);
      clr_halt_i = 1'b1;
      @(negedge clk);
      clr_halt_i = 1'b0;
      #1 chk("R7 halt cleared", {31'd0, halt_o}, 32'd0);
    end
    clr_halt_i = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin : main
    logic [7:0] ops [0:5];
    int         lens [0:3];
    logic [7:0] b;
    ops[0] = 8'h41; ops[1] = 8'h42; ops[2] = 8'h43;
    ops[3] = 8'h81; ops[4] = 8'h82; ops[5] = 8'h83;
    lens[0] = 0; lens[1] = 1; lens[2] = 5; lens[3] = 17;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R10 halt", {31'd0, halt_o}, 32'd0);
    chk("R10 done", {31'd0, done_o}, 32'd0);
    chk("R10 out_valid", {31'd0, out_valid_o}, 32'd0);
    chk("R10 desc_ready", {31'd0, desc_ready_o}, 32'd1);
    chk("R10 crc_o", crc_o, 32'h0);

    // R2 known vector "123456789"
    for (int i = 0; i < 9; i++) src[i] = 8'h31 + 8'(i);
    run(8'h81, 9, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R2 check value", crc_o, 32'hE306_9283);

    // R1 unsupported opcode, clear held high (R7 set wins)
    run(8'h85, 3, 32'hAAAA_5555, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R1 accumulator untouched", crc_o, 32'hE306_9283);

    for (int o = 0; o < 6; o++)
      for (int l = 0; l < 2; l++)
        for (int n = 0; n < 4; n++) begin
          bit corrupt;
          for (int i = 0; i < lens[n]; i++) begin next_rand(b); src[i] = b; end
          corrupt = (ops[o][1:0] == 2'b10) && (lens[n] == 5);
          run(ops[o], lens[n], lfsr ^ 32'h5A5A_0F0F, lens[n] == 1, l == 1,
              corrupt, corrupt && (l == 1));
        end

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule